// File: doc/BRIEF.md
# Flash Erase Suspend and Resume Sequencer

This block sits on the host side of a flash bus. It pauses a block erase that is already running so the host can read the array, and then lets the erase continue. When the host asks for a suspend, the sequencer writes the suspend command to the erasing block. It then polls the status register by pulsing output enable until the device reports ready. Next it puts the device into read-array mode and opens a window for host reads. When the host closes the window, the sequencer writes the resume command.

The device can report ready with its suspended flag clear. This means the erase finished before the suspend took effect. In that case the sequencer raises `erase_done`, still serves the host reads, and writes no resume command.

A mode input selects byte-wide or word-wide operation. In word mode one bus cycle reaches two byte devices side by side. Each command byte is repeated on both lanes, and both status bytes are evaluated. Polling is bounded: if ready never appears within a set number of status reads, the sequencer raises `timeout` and goes back to idle.

Top module: `erase_suspend_seq`

## Requirements
- R1: An accepted suspend request causes one flash write cycle with data B0h at the latched block address. In byte mode the data is 00B0h, and in word mode it is B0B0h.
- R2: Status is read with one output-enable low pulse per poll, and output enable goes high between polls. Polling stops on the first read that reports ready.
- R3: In byte mode only status bits 7 (ready) and 6 (suspended) are evaluated. The upper status byte has no effect.
- R4: In word mode the device counts as ready only when bits 7 and 15 are both set.
- R5: Once ready, the sequencer writes the read-array command (FFh, or FFFFh in word mode) to the block address. It then raises `rd_ready`, and each accepted read returns the flash data at `rd_addr` on `rd_data` with a one-cycle `rd_data_valid` pulse.
- R6: If the device reported suspended, closing the window with `resume_req` causes one write of D0h (D0D0h in word mode) to the block address.
- R7: If the device reports ready with suspend clear, `erase_done` rises, reads are still served, and no resume write is issued. In word mode "suspend clear" means bits 6 and 14 are both clear.
- R8: If MAX_POLLS status reads in a row all report busy, `timeout` rises and the sequencer returns to idle. It opens no read window and issues no further write.
- R9: `busy` is high from the cycle after an accepted suspend request until the sequence ends: after the resume write, after the window closes, or after a timeout.
- R10: In word mode the sequence counts as suspended if either bit 6 or bit 14 is set, and the resume write is issued.
- R11: A suspend request is ignored while `busy` is high. Exactly one suspend write is issued per sequence.
- R12: In byte mode the upper byte of `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_mode | input | 1 | 1 selects word-wide (paired device) operation; latched with the suspend request |
| susp_req | input | 1 | Request to suspend the running erase |
| blk_addr | input | AW | Address inside the block (or block pair) being erased |
| rd_valid | input | 1 | Host read request, taken while rd_ready is high |
| rd_addr | input | AW | Host read address |
| rd_ready | output | 1 | Read window is open and a read can be accepted |
| rd_data | output | 8*LANES | Read result |
| rd_data_valid | output | 1 | One-cycle strobe for rd_data |
| resume_req | input | 1 | Host has finished reading; close the window |
| fl_addr | output | AW | Flash address |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_dq_out | output | 8*LANES | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8*LANES | Data returned by the flash |
| busy | output | 1 | Sequence in progress |
| erase_done | output | 1 | The erase had already completed; held until the next accepted request |
| timeout | output | 1 | Ready never seen; held until the next accepted request |

## Verification
The bench drives a device model in which each lane becomes ready after its own number of status reads and reports its own suspended bit. It targets these corner cases:

- **Uneven lanes in word mode.** A design that tests only one lane would stop polling too early, as soon as the faster lane is ready.
- **Garbage in the upper status byte in byte mode.** A design that evaluates that byte would keep polling until timeout, or take the wrong path.
- **Suspended bit set in only one lane.** A design that ANDs the two lanes would skip a resume that is needed.
- **Erase already finished.** A design that misses this case would write a stray resume command.
- **A device that never becomes ready.** This checks the exact number of polls before timeout and that the read window stays closed.
- **A repeated suspend request while busy.** A design that re-arms on it would issue a second suspend write.

// File: rtl/ess_pkg.sv
// Shared types and command codes for the erase suspend sequencer.
// Assumes: one bus cycle per state; command bytes repeat on each active lane.
package ess_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_SUSP,
        S_POLL_LO,
        S_POLL_SMP,
        S_POLL_GAP,
        S_WR_RDARR,
        S_WIN,
        S_RD_LO,
        S_RD_SMP,
        S_WR_RES
    } ess_state_e;

    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RESUME     = 8'hD0;

    localparam int unsigned BIT_READY = 7;
    localparam int unsigned BIT_SUSP  = 6;

endpackage

// File: rtl/ess_status_eval.sv
// Status decoder: folds the per-lane ready and suspended bits into one verdict.
// Assumes: lane 0 is always active; all lanes are active in word mode.
module ess_status_eval #(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0] status,
    input  logic               word_mode,
    output logic               ready,
    output logic               suspended
);
    import ess_pkg::*;

    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_rdy;
    logic [LANES-1:0] lane_sus;

    // Split the status word into per-lane flags.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i]  = (i == 0) ? 1'b1 : word_mode;
        assign lane_rdy[i] = status[8*i + BIT_READY];
        assign lane_sus[i] = status[8*i + BIT_SUSP];
    end

    // Ready needs every active lane; suspended needs any active lane.
    always_comb begin
        ready     = &(lane_rdy | ~lane_en);
        suspended = |(lane_sus & lane_en);
    end

endmodule

// File: rtl/ess_poll_timer.sv
// Poll bound: counts busy status reads and flags the last allowed one.
// Assumes: clear is held while the sequencer is idle.
module ess_poll_timer #(
    parameter int MAX_POLLS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    // Count busy polls since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the poll that uses up the budget.
    always_comb begin
        expired = tick && (cnt == CW'(MAX_POLLS - 1));
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_POLLS - 1)); // R8

endmodule

// File: rtl/ess_bus_drive.sv
// Flash bus driver: turns the sequencer state into strobes, address and data.
// Assumes: state is registered, so the outputs change only after a clock edge.
module ess_bus_drive #(
    parameter int AW    = 20,
    parameter int LANES = 2
) (
    input  ess_pkg::ess_state_e  state,
    input  logic [AW-1:0]        blk_addr,
    input  logic [AW-1:0]        rd_addr,
    input  logic                 word_mode,
    output logic                 we_n,
    output logic                 oe_n,
    output logic [AW-1:0]        addr,
    output logic [8*LANES-1:0]   dq_out,
    output logic                 dq_oe
);
    import ess_pkg::*;

    logic [7:0] cmd;

    // Pick the strobes and the command byte for each state.
    always_comb begin
        we_n = 1'b1;
        oe_n = 1'b1;
        cmd  = 8'h00;
        addr = blk_addr;
        case (state)
            S_WR_SUSP:  begin we_n = 1'b0; cmd = CMD_SUSPEND;    end
            S_WR_RDARR: begin we_n = 1'b0; cmd = CMD_READ_ARRAY; end
            S_WR_RES:   begin we_n = 1'b0; cmd = CMD_RESUME;     end
            S_POLL_LO,
            S_POLL_SMP: oe_n = 1'b0;
            S_RD_LO,
            S_RD_SMP:   begin oe_n = 1'b0; addr = rd_addr; end
            default:    ;
        endcase
        dq_oe = !we_n;
    end

    // Repeat the command byte on every active lane.
    for (genvar i = 0; i < LANES; i++) begin : g_dq
        assign dq_out[8*i +: 8] = ((i == 0) || word_mode) ? cmd : 8'h00;
    end

    // A write strobe and an output enable must never overlap.
    always_comb begin
        AST_NO_BUS_FIGHT: assert (we_n || oe_n); // R2
    end

endmodule

// File: rtl/erase_suspend_seq.sv
// Erase suspend/resume sequencer (top level).
// Writes suspend, polls status, enters read-array mode, serves host reads and
// resumes when the erase was really suspended.
// Assumes: the host keeps rd_valid low outside the window; the flash answers
// within one output-enable cycle.
module erase_suspend_seq #(
    parameter int AW        = 20,
    parameter int LANES     = 2,
    parameter int MAX_POLLS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_mode,
    input  logic                 susp_req,
    input  logic [AW-1:0]        blk_addr,
    input  logic                 rd_valid,
    input  logic [AW-1:0]        rd_addr,
    output logic                 rd_ready,
    output logic [8*LANES-1:0]   rd_data,
    output logic                 rd_data_valid,
    input  logic                 resume_req,
    output logic [AW-1:0]        fl_addr,
    output logic                 fl_we_n,
    output logic                 fl_oe_n,
    output logic [8*LANES-1:0]   fl_dq_out,
    output logic                 fl_dq_oe,
    input  logic [8*LANES-1:0]   fl_dq_in,
    output logic                 busy,
    output logic                 erase_done,
    output logic                 timeout
);
    import ess_pkg::*;

    localparam int DW = 8 * LANES;

    ess_state_e     state, state_nx;
    logic [AW-1:0]  blk_q, rda_q;
    logic           mode_q, susp_q, done_q, tmo_q;
    logic [DW-1:0]  rdd_q;
    logic           rdv_q;
    logic           st_ready, st_susp, poll_expired, poll_tick;
    logic [DW-1:0]  lane_mask;

    ess_status_eval #(.LANES(LANES)) u_eval (
        .status    (fl_dq_in),
        .word_mode (mode_q),
        .ready     (st_ready),
        .suspended (st_susp)
    );

    assign poll_tick = (state == S_POLL_SMP) && !st_ready;

    ess_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == S_IDLE),
        .tick    (poll_tick),
        .expired (poll_expired)
    );

    ess_bus_drive #(.AW(AW), .LANES(LANES)) u_bus (
        .state     (state),
        .blk_addr  (blk_q),
        .rd_addr   (rda_q),
        .word_mode (mode_q),
        .we_n      (fl_we_n),
        .oe_n      (fl_oe_n),
        .addr      (fl_addr),
        .dq_out    (fl_dq_out),
        .dq_oe     (fl_dq_oe)
    );

    // Keep only lane 0 of read data in byte mode.
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign lane_mask[8*i +: 8] = ((i == 0) || mode_q) ? 8'hFF : 8'h00;
    end

    // Next-state logic of the sequence.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:     if (susp_req) state_nx = S_WR_SUSP;
            S_WR_SUSP:  state_nx = S_POLL_LO;
            S_POLL_LO:  state_nx = S_POLL_SMP;
            S_POLL_SMP: begin
                if (st_ready)          state_nx = S_WR_RDARR;
                else if (poll_expired) state_nx = S_IDLE;
                else                   state_nx = S_POLL_GAP;
            end
            S_POLL_GAP: state_nx = S_POLL_LO;
            S_WR_RDARR: state_nx = S_WIN;
            S_WIN: begin
                if (rd_valid)        state_nx = S_RD_LO;
                else if (resume_req) state_nx = susp_q ? S_WR_RES : S_IDLE;
            end
            S_RD_LO:    state_nx = S_RD_SMP;
            S_RD_SMP:   state_nx = S_WIN;
            S_WR_RES:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Latch the request context and the status verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            mode_q <= 1'b0;
            susp_q <= 1'b0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (state == S_IDLE && susp_req) begin
            blk_q  <= blk_addr;
            mode_q <= word_mode;
            susp_q <= 1'b0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (state == S_POLL_SMP) begin
            if (st_ready) begin
                susp_q <= st_susp;
                done_q <= !st_susp;
            end else if (poll_expired) begin
                tmo_q  <= 1'b1;
            end
        end
    end

    // Host read path: take the address, capture the flash data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rda_q <= '0;
            rdd_q <= '0;
            rdv_q <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            if (state == S_WIN && rd_valid) rda_q <= rd_addr;
            if (state == S_RD_SMP) begin
                rdd_q <= fl_dq_in & lane_mask;
                rdv_q <= 1'b1;
            end
        end
    end

    assign rd_ready      = (state == S_WIN);
    assign rd_data       = rdd_q;
    assign rd_data_valid = rdv_q;
    assign busy          = (state != S_IDLE);
    assign erase_done    = done_q;
    assign timeout       = tmo_q;

    AST_SUSP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !fl_we_n && fl_dq_out[7:0] == CMD_SUSPEND); // R1
    AST_DONE_NOT_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_done && timeout)); // R8
    AST_NO_WIN_AFTER_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !rd_ready && fl_we_n); // R8
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |=> !rd_data_valid); // R5
    AST_NO_RESUME_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && !fl_we_n) |-> fl_dq_out[7:0] != CMD_RESUME); // R7

endmodule

// File: tb/sim_erase_suspend_seq.sv
// Bench: device model with per-lane ready delay and suspended flag, random and
// directed sequences, expected values from bench functions.
module sim_erase_suspend_seq;

    localparam int AW = 20;
    localparam int MAXP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b0, susp_req = 1'b0, rd_valid = 1'b0, resume_req = 1'b0;
    logic [AW-1:0] blk_addr = '0, rd_addr = '0;
    logic        rd_ready, rd_data_valid, fl_we_n, fl_oe_n, fl_dq_oe, busy, erase_done, timeout;
    logic [15:0] rd_data, fl_dq_out, fl_dq_in;
    logic [AW-1:0] fl_addr;

    int checks = 0, fails = 0, cycles = 0;

    // device model state
    int  need0 = 0, need1 = 0, polls_seen = 0, wcount = 0;
    bit  s0 = 0, s1 = 0, status_mode = 0;
    logic prev_oe = 1'b1;
    logic [15:0] wr_data [8];
    logic [AW-1:0] wr_addr [8];

    always #4 clk = ~clk;

    erase_suspend_seq #(.AW(AW), .LANES(2), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .susp_req(susp_req),
        .blk_addr(blk_addr), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_data_valid(rd_data_valid), .resume_req(resume_req),
        .fl_addr(fl_addr), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .busy(busy), .erase_done(erase_done),
        .timeout(timeout)
    );

    function automatic logic [15:0] mem_fn(logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[19:16], 12'h000};
    endfunction

    function automatic logic [15:0] cmd_fn(logic [7:0] c, bit w);
        return w ? {c, c} : {8'h00, c};
    endfunction

    // Flash answer: status bytes in status mode, array data otherwise.
    always_comb begin
        if (status_mode)
            fl_dq_in = {polls_seen >= need1, (polls_seen >= need1) && s1, 6'b0,
                        polls_seen >= need0, (polls_seen >= need0) && s0, 6'b0};
        else
            fl_dq_in = mem_fn(fl_addr);
    end

    // Bus monitor: logs writes, tracks device mode, counts status reads.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        prev_oe <= fl_oe_n;
        if (status_mode && fl_oe_n && !prev_oe) polls_seen <= polls_seen + 1;
        if (!fl_we_n) begin
            if (wcount < 8) begin
                wr_data[wcount] <= fl_dq_out;
                wr_addr[wcount] <= fl_addr;
            end
            wcount <= wcount + 1;
            if (fl_dq_out[7:0] == 8'hB0) begin status_mode <= 1; polls_seen <= 0; end
            if (fl_dq_out[7:0] == 8'hFF) status_mode <= 0;
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(bit w, logic [AW-1:0] blk, int n0, int n1, bit a0, bit a1,
                            int nreads, bit dup);
        int  exp_need = (w && n1 > n0) ? n1 : n0;
        bit  exp_rdy  = exp_need < MAXP;
        bit  exp_sus  = w ? (a0 | a1) : a0;
        int  exp_w    = !exp_rdy ? 1 : (exp_sus ? 3 : 2);
        logic [15:0] exp_d;
        @(negedge clk);
        need0 = n0; need1 = n1; s0 = a0; s1 = a1; wcount = 0;
        word_mode = w; blk_addr = blk; susp_req = 1'b1;
        @(negedge clk);
        susp_req = 1'b0;
        check(busy == 1'b1, "R9 busy after request", busy, 1);
        check(!fl_we_n && fl_dq_out == cmd_fn(8'hB0, w) && fl_addr == blk,
              "R1 suspend write", fl_dq_out, cmd_fn(8'hB0, w));
        if (dup) begin
            @(negedge clk) susp_req = 1'b1;
            @(negedge clk) susp_req = 1'b0;
        end
        for (int i = 0; i < 600 && !rd_ready && busy; i++) @(negedge clk);
        check(rd_ready == exp_rdy, exp_rdy ? "R5 window opens" : "R8 window stays closed",
              rd_ready, exp_rdy);
        if (rd_ready) begin
            check(erase_done == !exp_sus, "R7 erase_done at ready", erase_done, !exp_sus);
            for (int k = 0; k < nreads; k++) begin
                rd_addr = AW'($urandom);
                rd_valid = 1'b1;
                exp_d = w ? mem_fn(rd_addr) : (mem_fn(rd_addr) & 16'h00FF);
                @(negedge clk) rd_valid = 1'b0;
                for (int i = 0; i < 10 && !rd_data_valid; i++) @(negedge clk);
                check(rd_data_valid && rd_data == exp_d, w ? "R5 read data" : "R12 byte read data",
                      rd_data, exp_d);
                check(busy, "R9 busy in window", busy, 1);
            end
            resume_req = 1'b1;
            @(negedge clk) resume_req = 1'b0;
        end
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        @(negedge clk);
        check(!busy, "R9 busy clears", busy, 0);
        check(timeout == !exp_rdy, "R8 timeout flag", timeout, !exp_rdy);
        check(erase_done == (exp_rdy && !exp_sus), "R7 erase_done flag", erase_done,
              exp_rdy && !exp_sus);
        check(polls_seen == (exp_rdy ? exp_need + 1 : MAXP),
              w ? "R4 R2 status read count" : "R3 R2 status read count",
              polls_seen, exp_rdy ? exp_need + 1 : MAXP);
        check(wcount == exp_w, dup ? "R11 write count" : "R6 R7 write count", wcount, exp_w);
        if (exp_rdy && wcount >= 2)
            check(wr_data[1] == cmd_fn(8'hFF, w) && wr_addr[1] == blk, "R5 read-array write",
                  wr_data[1], cmd_fn(8'hFF, w));
        if (exp_rdy && exp_sus && wcount >= 3)
            check(wr_data[2] == cmd_fn(8'hD0, w) && wr_addr[2] == blk,
                  w ? "R10 R6 resume write" : "R6 resume write", wr_data[2], cmd_fn(8'hD0, w));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_we_n && fl_oe_n && !fl_dq_oe && !busy && !erase_done && !timeout && !rd_ready,
              "R9 reset state", {fl_we_n, fl_oe_n, fl_dq_oe, busy}, 4'b1100);
        // directed corners
        run_case(0, 20'h1A000, 2, 1000, 0, 1, 2, 0);  // R3 upper lane garbage ignored
        run_case(1, 20'h2B000, 0, 4, 1, 1, 2, 0);     // R4 uneven lanes
        run_case(1, 20'h3C000, 1, 1, 0, 1, 1, 0);     // R10 one lane suspended
        run_case(1, 20'h4D000, 2, 0, 0, 0, 3, 0);     // R7 erase finished
        run_case(0, 20'h5E000, 1000, 0, 1, 0, 0, 0);  // R8 never ready
        run_case(0, 20'h6F000, 3, 0, 1, 0, 1, 1);     // R11 repeated request
        // random sequences
        for (int n = 0; n < 24; n++)
            run_case($urandom % 2, AW'($urandom), $urandom % 6, $urandom % 6,
                     $urandom % 2, $urandom % 2, $urandom % 5, $urandom % 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule